// File: doc/BRIEF.md
# Circular Trace Memory Address Generator

This block produces the store address for a stream of 32-bit trace words written into a memory window that software defines. Software programs a lower and an upper bound for the window. A read-only current-address register always holds the location that the next accepted word will be written to. Each word strobe that the block accepts is presented on the address output in the same cycle, and the current address then moves on by one word.

A mode bit selects what happens at the upper bound. In wrap mode the next word goes back to the lower bound. In stop mode the block freezes at the upper bound and drops every later word. A reload command written by software sends the current address back to the lower bound and ends a stop. Two sticky event bits, each with an enable bit and a write-one-to-clear bit, drive a single interrupt line. One bit records a FIFO overflow or a dropped word. The other records that a word landed at the upper bound.

Top module: `trace_win_addr`

## Requirements
- R1: After reset the lower bound reads 0, the upper bound reads 0xFFFFFFFF, the current address reads 0, the control register reads 0x2 (wrap mode on), enables and raw events read 0, and `irq` is 0.
- R2: When `wordStrobe` is high and the block is not stopped, `memWrValid` is 1 and `memAddr` equals the current address in that cycle. If that address is below the upper bound, the current address is 4 higher in the next cycle.
- R3: In wrap mode (control bit 1 = 1), a word accepted at an address greater than or equal to the upper bound makes the next current address equal to the lower bound.
- R4: In stop mode (control bit 1 = 0), a word accepted at or beyond the upper bound is written, and the current address then stays where it is. Later strobes give `memWrValid` = 0 and leave the current address unchanged.
- R5: Raw event bit 0 (overflow) is set by a high `fifoOverflow` input, and also by a strobe that is dropped while the block is stopped.
- R6: Raw event bit 1 (memory full) is set in either mode when a word is accepted at or beyond the upper bound. It stays set until it is cleared.
- R7: Writing the clear register (index 6) clears each raw bit that has a 1 in the written data. A 0 in the data leaves the bit unchanged. A set event in the same cycle wins over a clear.
- R8: `irq` equals the OR over both sources of raw bit AND enable bit. The enable register is at index 5, with bit 0 for overflow and bit 1 for memory full.
- R9: Writing control (index 3) with bit 0 = 1 loads the current address from the lower bound in the next cycle and ends a stop. This takes priority over an advance in the same cycle. Bit 0 always reads back as 0.
- R10: Register indices are 0 for the lower bound (R/W), 1 for the upper bound (R/W), 2 for the current address (read-only, writes ignored) and 4 for raw events (read-only). Reads return the value in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regIdx | input | 3 | Register index for reads and writes |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for `regIdx` |
| wordStrobe | input | 1 | Request to store one trace word |
| fifoOverflow | input | 1 | Overflow event from the upstream FIFO |
| memWrValid | output | 1 | The word is accepted at `memAddr` |
| memAddr | output | 32 | Store address for the current word |
| irq | output | 1 | Interrupt request |

## Verification
The bench steps across a small window and then writes at the upper bound itself. A design with an off-by-one compare would either wrap one word early or write past the bound, and a design without the sticky full bit would lose the event. In stop mode, a design that keeps advancing or fails to flag the dropped strobe shows a wrong address or a clear overflow bit. The bench also clears an event in the same cycle the event fires, and issues a reload in the same cycle as a strobe. These checks catch a clear that wins over a set and an advance that wins over the reload.

// File: rtl/trace_win_pkg.sv
package trace_win_pkg;
  localparam int REG_IDX_W = 3;
  localparam logic [REG_IDX_W-1:0] IDX_LOWER = 3'd0;
  localparam logic [REG_IDX_W-1:0] IDX_UPPER = 3'd1;
  localparam logic [REG_IDX_W-1:0] IDX_CUR   = 3'd2;
  localparam logic [REG_IDX_W-1:0] IDX_CTRL  = 3'd3;
  localparam logic [REG_IDX_W-1:0] IDX_RAW   = 3'd4;
  localparam logic [REG_IDX_W-1:0] IDX_EN    = 3'd5;
  localparam logic [REG_IDX_W-1:0] IDX_CLR   = 3'd6;
  localparam int EV_N    = 2;
  localparam int EV_OVF  = 0;
  localparam int EV_FULL = 1;

  typedef struct packed {
    logic wrLower;
    logic wrUpper;
    logic reload;
    logic advance;
    logic wrapToLower;
  } winCmd_t;
endpackage

// File: rtl/trace_win_path.sv
module trace_win_path
  import trace_win_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STRIDE = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  winCmd_t           cmd,
  input  logic [ADDR_W-1:0] wrData,
  output logic [ADDR_W-1:0] lowerQ,
  output logic [ADDR_W-1:0] upperQ,
  output logic [ADDR_W-1:0] curQ,
  output logic              atUpper
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STRIDE);

  assign atUpper = (curQ >= upperQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowerQ <= '0;
      upperQ <= '1;
      curQ   <= '0;
    end else begin
      if (cmd.wrLower) lowerQ <= wrData;
      if (cmd.wrUpper) upperQ <= wrData;
      if (cmd.reload || cmd.wrapToLower) curQ <= lowerQ;
      else if (cmd.advance)              curQ <= curQ + STEP;
    end
  end

  assert_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.advance && !cmd.reload) |=> (curQ == $past(curQ) + STEP));

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.wrapToLower && !cmd.reload) |=> (curQ == $past(lowerQ)));

  assert_reload_R9: assert property (@(posedge clk) disable iff (!rstN)
    cmd.reload |=> (curQ == $past(lowerQ)));
endmodule

// File: rtl/trace_win_ctrl.sv
module trace_win_ctrl
  import trace_win_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWe,
  input  logic [REG_IDX_W-1:0] regIdx,
  input  logic [ADDR_W-1:0]    regWdata,
  output logic [ADDR_W-1:0]    regRdata,
  input  logic                 wordStrobe,
  input  logic                 fifoOverflow,
  input  logic                 atUpper,
  input  logic [ADDR_W-1:0]    lowerQ,
  input  logic [ADDR_W-1:0]    upperQ,
  input  logic [ADDR_W-1:0]    curQ,
  output winCmd_t              cmd,
  output logic                 memWrValid,
  output logic                 irq
);
  logic            wrapModeQ;
  logic            stoppedQ;
  logic [EV_N-1:0] enQ;
  logic [EV_N-1:0] rawQ;
  logic [EV_N-1:0] setVec;
  logic [EV_N-1:0] clrVec;
  logic            wrCtrl;
  logic            wrClr;
  logic            reloadReq;
  logic            accept;

  assign wrCtrl    = regWe && (regIdx == IDX_CTRL);
  assign wrClr     = regWe && (regIdx == IDX_CLR);
  assign reloadReq = wrCtrl && regWdata[0];
  assign accept    = wordStrobe && !stoppedQ;
  assign memWrValid = accept;

  always_comb begin
    cmd             = '0;
    cmd.wrLower     = regWe && (regIdx == IDX_LOWER);
    cmd.wrUpper     = regWe && (regIdx == IDX_UPPER);
    cmd.reload      = reloadReq;
    cmd.advance     = accept && !atUpper;
    cmd.wrapToLower = accept && atUpper && wrapModeQ;
  end

  always_comb begin
    setVec          = '0;
    setVec[EV_OVF]  = fifoOverflow || (wordStrobe && stoppedQ);
    setVec[EV_FULL] = accept && atUpper;
    clrVec          = wrClr ? regWdata[EV_N-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrapModeQ <= 1'b1;
      stoppedQ  <= 1'b0;
      enQ       <= '0;
      rawQ      <= '0;
    end else begin
      if (wrCtrl) wrapModeQ <= regWdata[1];
      if (regWe && (regIdx == IDX_EN)) enQ <= regWdata[EV_N-1:0];
      if (reloadReq)                              stoppedQ <= 1'b0;
      else if (accept && atUpper && !wrapModeQ)   stoppedQ <= 1'b1;
      rawQ <= (rawQ & ~clrVec) | setVec;
    end
  end

  assign irq = |(rawQ & enQ);

  always_comb begin
    unique case (regIdx)
      IDX_LOWER: regRdata = lowerQ;
      IDX_UPPER: regRdata = upperQ;
      IDX_CUR:   regRdata = curQ;
      IDX_CTRL:  regRdata = ADDR_W'({wrapModeQ, 1'b0});
      IDX_RAW:   regRdata = ADDR_W'(rawQ);
      IDX_EN:    regRdata = ADDR_W'(enQ);
      default:   regRdata = '0;
    endcase
  end

  assert_stop_blocks_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memWrValid && atUpper && !wrapModeQ && !reloadReq) |=> !memWrValid);

  assert_drop_flags_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wordStrobe && !memWrValid) |=> rawQ[EV_OVF]);

  assert_full_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rawQ[EV_FULL] && !(wrClr && regWdata[EV_FULL])) |=> rawQ[EV_FULL]);

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    fifoOverflow |=> rawQ[EV_OVF]);
endmodule

// File: rtl/trace_win_addr.sv
module trace_win_addr
  import trace_win_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STRIDE = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWe,
  input  logic [REG_IDX_W-1:0] regIdx,
  input  logic [ADDR_W-1:0]    regWdata,
  output logic [ADDR_W-1:0]    regRdata,
  input  logic                 wordStrobe,
  input  logic                 fifoOverflow,
  output logic                 memWrValid,
  output logic [ADDR_W-1:0]    memAddr,
  output logic                 irq
);
  winCmd_t           cmd;
  logic [ADDR_W-1:0] lowerQ;
  logic [ADDR_W-1:0] upperQ;
  logic [ADDR_W-1:0] curQ;
  logic              atUpper;

  trace_win_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regIdx(regIdx),
    .regWdata(regWdata), .regRdata(regRdata), .wordStrobe(wordStrobe),
    .fifoOverflow(fifoOverflow), .atUpper(atUpper), .lowerQ(lowerQ),
    .upperQ(upperQ), .curQ(curQ), .cmd(cmd), .memWrValid(memWrValid),
    .irq(irq)
  );

  trace_win_path #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) uPath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrData(regWdata),
    .lowerQ(lowerQ), .upperQ(upperQ), .curQ(curQ), .atUpper(atUpper)
  );

  assign memAddr = curQ;
endmodule

// File: tb/trace_win_addr_test.sv
module trace_win_addr_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regIdx = 3'd0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        wordStrobe = 1'b0;
  logic        fifoOverflow = 1'b0;
  logic        memWrValid;
  logic [31:0] memAddr;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  trace_win_addr uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regIdx(regIdx),
    .regWdata(regWdata), .regRdata(regRdata), .wordStrobe(wordStrobe),
    .fifoOverflow(fifoOverflow), .memWrValid(memWrValid),
    .memAddr(memAddr), .irq(irq)
  );

  task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got 0x%08h expected 0x%08h", req, what, got, exp);
    end
  endtask

  task automatic regWrite(logic [2:0] idx, logic [31:0] data);
    @(negedge clk);
    regWe = 1'b1; regIdx = idx; regWdata = data;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic regCheck(string req, logic [2:0] idx, logic [31:0] exp);
    regIdx = idx;
    #1;
    check(req, $sformatf("reg[%0d]", idx), regRdata, exp);
  endtask

  task automatic push(string req, logic expValid, logic [31:0] expAddr);
    @(negedge clk);
    wordStrobe = 1'b1;
    #1;
    check(req, "memWrValid", 32'(memWrValid), 32'(expValid));
    check(req, "memAddr", memAddr, expAddr);
    @(negedge clk);
    wordStrobe = 1'b0;
  endtask

  task automatic tReset();
    regCheck("R1", 3'd0, 32'h0);
    regCheck("R1", 3'd1, 32'hFFFF_FFFF);
    regCheck("R1", 3'd2, 32'h0);
    regCheck("R1", 3'd3, 32'h2);
    regCheck("R1", 3'd4, 32'h0);
    regCheck("R1", 3'd5, 32'h0);
    check("R1", "irq", 32'(irq), 32'h0);
  endtask

  task automatic tStride();
    regWrite(3'd0, 32'h100);
    regWrite(3'd1, 32'h10C);
    regCheck("R10", 3'd0, 32'h100);
    regCheck("R10", 3'd1, 32'h10C);
    regWrite(3'd3, 32'h3);
    regCheck("R9", 3'd2, 32'h100);
    regCheck("R9", 3'd3, 32'h2);
    push("R2", 1'b1, 32'h100);
    push("R2", 1'b1, 32'h104);
    push("R2", 1'b1, 32'h108);
    regCheck("R2", 3'd2, 32'h10C);
    regCheck("R6", 3'd4, 32'h0);
  endtask

  task automatic tWrap();
    push("R3", 1'b1, 32'h10C);
    regCheck("R3", 3'd2, 32'h100);
    regCheck("R6", 3'd4, 32'h2);
    push("R3", 1'b1, 32'h100);
    regCheck("R6", 3'd4, 32'h2);
  endtask

  task automatic tEvents();
    regWrite(3'd6, 32'h0);
    regCheck("R7", 3'd4, 32'h2);
    check("R8", "irq off", 32'(irq), 32'h0);
    regWrite(3'd5, 32'h2);
    #1 check("R8", "irq full", 32'(irq), 32'h1);
    regWrite(3'd5, 32'h1);
    #1 check("R8", "irq masked", 32'(irq), 32'h0);
    regWrite(3'd6, 32'h2);
    regCheck("R7", 3'd4, 32'h0);
    @(negedge clk);
    regWe = 1'b1; regIdx = 3'd6; regWdata = 32'h1; fifoOverflow = 1'b1;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0; fifoOverflow = 1'b0;
    regCheck("R5", 3'd4, 32'h1);
    check("R8", "irq ovf", 32'(irq), 32'h1);
    regWrite(3'd6, 32'h1);
    regCheck("R7", 3'd4, 32'h0);
    check("R8", "irq cleared", 32'(irq), 32'h0);
    regWrite(3'd5, 32'h0);
  endtask

  task automatic tStop();
    regWrite(3'd3, 32'h1);
    regCheck("R4", 3'd3, 32'h0);
    regCheck("R9", 3'd2, 32'h100);
    push("R4", 1'b1, 32'h100);
    push("R4", 1'b1, 32'h104);
    push("R4", 1'b1, 32'h108);
    push("R4", 1'b1, 32'h10C);
    regCheck("R4", 3'd2, 32'h10C);
    regCheck("R6", 3'd4, 32'h2);
    push("R4", 1'b0, 32'h10C);
    push("R4", 1'b0, 32'h10C);
    regCheck("R4", 3'd2, 32'h10C);
    regCheck("R5", 3'd4, 32'h3);
  endtask

  task automatic tReload();
    regWrite(3'd3, 32'h1);
    regCheck("R9", 3'd2, 32'h100);
    push("R9", 1'b1, 32'h100);
    @(negedge clk);
    regWe = 1'b1; regIdx = 3'd3; regWdata = 32'h3; wordStrobe = 1'b1;
    #1;
    check("R9", "memWrValid same cycle", 32'(memWrValid), 32'h1);
    check("R9", "memAddr same cycle", memAddr, 32'h104);
    @(negedge clk);
    regWe = 1'b0; regWdata = '0; wordStrobe = 1'b0;
    regCheck("R9", 3'd2, 32'h100);
    regCheck("R3", 3'd3, 32'h2);
    regWrite(3'd2, 32'hDEAD_BEEF);
    regCheck("R10", 3'd2, 32'h100);
    regWrite(3'd4, 32'h0);
    regCheck("R10", 3'd4, 32'h3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tStride();
    tWrap();
    tEvents();
    tStop();
    tReload();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule